// File: doc/BRIEF.md
# Infrared Serial Port Register and FIFO Interface

This block is the processor-facing part of a high-speed infrared serial port. It decodes a small byte-wide register bus into three control registers, one data address and two status registers. Writing the data address pushes a byte toward the transmit shifter, and reading the same address pops a byte that the receive shifter delivered. Shifters, CRC logic, pulse modulation and frame synchronization sit outside the block. They talk to it through byte handshakes and one-cycle event strobes.

The transmit and receive paths run independently, and both may be active at once. A loopback control routes the transmit serial bit straight into the receive serial input and hands the line pins to an outside pin controller. Error conditions are held in sticky bits that software clears by writing ones. Service requests and FIFO levels are reported live. One interrupt request combines the sticky bits and the two service requests. Busy, synchronized and FIFO-level flags never raise it.

Top module: `irport_regs`

## Requirements
- R1: After reset all control fields read zero. Address 0 holds six control bits (bit0 transmit enable, bit1 receive enable, bit2 loopback, bit3 abort-on-underrun, bit4 transmit invert, bit5 receive invert). Address 1 holds three bits (bit0 transmit service enable, bit1 receive service enable, bit2 address match enable). Address 2 holds the 8-bit match value. Unused bits read zero.
- R2: A bus write to address 3 pushes the byte into the transmit FIFO. While the FIFO is not empty, `tx_data` shows its oldest byte, and an enabled `tx_pop_req` removes that byte. Bytes leave in write order.
- R3: A bus read of address 3 returns the oldest received byte and removes it. A read while the receive FIFO is empty returns zero and leaves the FIFO unchanged.
- R4: A data write while the transmit FIFO is full (DEPTH entries) is dropped.
- R5: A received byte that arrives while the receive FIFO is full is dropped and sets the overrun sticky bit.
- R6: Address 4 holds sticky bits: bit0 CRC error, bit1 overrun, bit2 underrun, bit3 framing error, bit4 receive abort, bit5 end of frame. Writing a one clears a bit. A set event in the same cycle as its clear wins.
- R7: Address 5 reports live flags: bit0 transmit service request, bit1 receive service request, bit2 transmitter busy, bit3 receiver synchronized, bit4 receive FIFO not empty, bit5 transmit FIFO not full.
- R8: The transmit service request is high when it is enabled and the transmit FIFO holds at most DEPTH/2 bytes. The receive service request is high when it is enabled and the receive FIFO holds at least DEPTH/2 bytes.
- R9: `irq` is high exactly when a sticky bit or a service request is set. Busy, synchronized and FIFO-level flags do not affect it.
- R10: An enabled `tx_pop_req` on an empty transmit FIFO sets the underrun bit. In that same cycle it raises `tx_end_abort` when abort-on-underrun is set, and `tx_end_eof` otherwise.
- R11: Without loopback, `pin_own` is 1, `pin_txd` is `tx_ser_in` XOR transmit invert, and `rx_ser_out` is `pin_rxd` XOR receive invert. With loopback, `pin_own` is 0, `pin_txd` is 0, and `rx_ser_out` follows `tx_ser_in`.
- R12: With matching enabled, a frame whose address byte (flagged by `rx_addr_flag`) differs from the match value is discarded, together with its following bytes, until the next address byte or end-of-frame strobe.
- R13: With the transmitter disabled, `tx_pop_req` does nothing. With the receiver disabled, received bytes and receive event strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus cycle select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops on the clock edge) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the read cycle |
| irq | output | 1 | Interrupt request |
| tx_pop_req | input | 1 | Transmit shifter takes one byte |
| tx_data | output | 8 | Oldest transmit byte, zero when empty |
| tx_end_abort | output | 1 | Underrun ends frame with abort |
| tx_end_eof | output | 1 | Underrun ends frame normally |
| tx_busy_in | input | 1 | Transmit shifter busy level |
| tx_ser_in | input | 1 | Transmit shifter serial bit |
| rx_byte_valid | input | 1 | Receive shifter delivers a byte |
| rx_byte | input | 8 | Received byte |
| rx_addr_flag | input | 1 | Delivered byte is a frame address |
| rx_crc_evt | input | 1 | CRC error strobe |
| rx_frame_evt | input | 1 | Framing error strobe |
| rx_abort_evt | input | 1 | Receive abort strobe |
| rx_eof_evt | input | 1 | Receive end of frame strobe |
| rx_sync_in | input | 1 | Receiver synchronized level |
| rx_ser_out | output | 1 | Serial bit to receive shifter |
| pin_rxd | input | 1 | Receive line pin |
| pin_txd | output | 1 | Transmit line pin |
| pin_own | output | 1 | 1 while this block owns the line pins |

## Verification
Most internal faults here show up at the bus one or two cycles later. A wrong FIFO pointer or count changes the byte read from address 3, or the FIFO-level bits at address 5, on the next access. A sticky bit that is lost or stuck appears at address 4 and on `irq` at the clock edge after the event. Underrun and loopback errors show within the same cycle on the frame-end strobes and the serial outputs. The bench therefore reads status right after each stimulus. It covers the FIFO boundaries at DEPTH/2 and DEPTH, set/clear collisions, and discarded address frames.

// File: rtl/irport_pkg.sv
package irport_pkg;

  localparam int unsigned AW_BUS = 3;

  localparam logic [AW_BUS-1:0] A_CTRL_MAIN  = 3'd0;
  localparam logic [AW_BUS-1:0] A_CTRL_SVC   = 3'd1;
  localparam logic [AW_BUS-1:0] A_CTRL_MATCH = 3'd2;
  localparam logic [AW_BUS-1:0] A_DATA       = 3'd3;
  localparam logic [AW_BUS-1:0] A_STICKY     = 3'd4;
  localparam logic [AW_BUS-1:0] A_LIVE       = 3'd5;

  // sticky bit positions
  localparam int unsigned S_CRC   = 0;
  localparam int unsigned S_OVR   = 1;
  localparam int unsigned S_UND   = 2;
  localparam int unsigned S_FRM   = 3;
  localparam int unsigned S_ABT   = 4;
  localparam int unsigned S_EOF   = 5;
  localparam int unsigned N_STICKY = 6;

  typedef struct packed {
    logic       tx_en;
    logic       rx_en;
    logic       loopback;
    logic       abort_mode;
    logic       tx_inv;
    logic       rx_inv;
    logic       txsr_en;
    logic       rxsr_en;
    logic       match_en;
    logic [7:0] match_val;
  } ctrl_t;

endpackage

// File: rtl/irport_fifo.sv
module irport_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CMAX);
  assign empty   = (cnt_q == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign rdata   = mem[rd_ptr_q];
  assign count   = cnt_q;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (do_push) wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
    if (do_pop)  rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= wdata;
  end

  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == $past(count)));

  // R3
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (count == '0));

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CMAX);

endmodule

// File: rtl/irport_sticky.sv
module irport_sticky #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);

  logic [N-1:0] q_q, q_d;

  always_comb begin
    q_d = (q_q & ~clr) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q = q_q;

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((q & $past(set)) == $past(set)));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr == '0) |=> ((q & $past(q)) == $past(q)));

endmodule

// File: rtl/irport_regs.sv
module irport_regs #(
  parameter int unsigned DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  input  logic       tx_pop_req,
  output logic [7:0] tx_data,
  output logic       tx_end_abort,
  output logic       tx_end_eof,
  input  logic       tx_busy_in,
  input  logic       tx_ser_in,
  input  logic       rx_byte_valid,
  input  logic [7:0] rx_byte,
  input  logic       rx_addr_flag,
  input  logic       rx_crc_evt,
  input  logic       rx_frame_evt,
  input  logic       rx_abort_evt,
  input  logic       rx_eof_evt,
  input  logic       rx_sync_in,
  output logic       rx_ser_out,
  input  logic       pin_rxd,
  output logic       pin_txd,
  output logic       pin_own
);
  import irport_pkg::*;

  localparam int unsigned DW = 8;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // bus decode
  logic wr_hit, rd_hit, tx_push, rx_pop;
  assign wr_hit  = bus_sel & bus_wr;
  assign rd_hit  = bus_sel & bus_rd;
  assign tx_push = wr_hit & (bus_addr == A_DATA);
  assign rx_pop  = rd_hit & (bus_addr == A_DATA);

  // control registers
  ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_hit) begin
      case (bus_addr)
        A_CTRL_MAIN: begin
          ctrl_d.tx_en      = bus_wdata[0];
          ctrl_d.rx_en      = bus_wdata[1];
          ctrl_d.loopback   = bus_wdata[2];
          ctrl_d.abort_mode = bus_wdata[3];
          ctrl_d.tx_inv     = bus_wdata[4];
          ctrl_d.rx_inv     = bus_wdata[5];
        end
        A_CTRL_SVC: begin
          ctrl_d.txsr_en  = bus_wdata[0];
          ctrl_d.rxsr_en  = bus_wdata[1];
          ctrl_d.match_en = bus_wdata[2];
        end
        A_CTRL_MATCH: ctrl_d.match_val = bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ctrl_q <= '0;
    else            ctrl_q <= ctrl_d;
  end

  // transmit FIFO
  logic [DW-1:0] tx_head;
  logic [CW-1:0] tx_count;
  logic          tx_full, tx_empty, tx_pop, tx_under;

  assign tx_pop   = tx_pop_req & ctrl_q.tx_en;
  assign tx_under = tx_pop & tx_empty;

  irport_fifo #(.W(DW), .DEPTH(DEPTH)) u_tx_fifo (
    .clk   (clk),
    .rst_n (rst_int_n),
    .push  (tx_push),
    .wdata (bus_wdata),
    .pop   (tx_pop),
    .rdata (tx_head),
    .count (tx_count),
    .full  (tx_full),
    .empty (tx_empty)
  );

  assign tx_data      = tx_empty ? '0 : tx_head;
  assign tx_end_abort = tx_under & ctrl_q.abort_mode;
  assign tx_end_eof   = tx_under & ~ctrl_q.abort_mode;

  // receive filtering with address match
  logic discard_q, discard_d;
  logic addr_miss, rx_take, rx_push;
  logic rx_live;

  assign rx_live   = rx_byte_valid & ctrl_q.rx_en;
  assign addr_miss = ctrl_q.match_en & rx_addr_flag & (rx_byte != ctrl_q.match_val);
  assign rx_take   = rx_live & ~addr_miss & ~(discard_q & ~rx_addr_flag);

  always_comb begin
    discard_d = discard_q;
    if (rx_live && rx_addr_flag) discard_d = addr_miss;
    if (ctrl_q.rx_en && rx_eof_evt) discard_d = 1'b0;
    if (!ctrl_q.match_en) discard_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) discard_q <= 1'b0;
    else            discard_q <= discard_d;
  end

  // receive FIFO
  logic [DW-1:0] rx_head;
  logic [CW-1:0] rx_count;
  logic          rx_full, rx_empty, rx_over;

  assign rx_push = rx_take;
  assign rx_over = rx_take & rx_full;

  irport_fifo #(.W(DW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk   (clk),
    .rst_n (rst_int_n),
    .push  (rx_push),
    .wdata (rx_byte),
    .pop   (rx_pop),
    .rdata (rx_head),
    .count (rx_count),
    .full  (rx_full),
    .empty (rx_empty)
  );

  // sticky status
  logic [N_STICKY-1:0] st_set, st_clr, st_q;

  always_comb begin
    st_set        = '0;
    st_set[S_CRC] = ctrl_q.rx_en & rx_crc_evt;
    st_set[S_OVR] = rx_over;
    st_set[S_UND] = tx_under;
    st_set[S_FRM] = ctrl_q.rx_en & rx_frame_evt;
    st_set[S_ABT] = ctrl_q.rx_en & rx_abort_evt;
    st_set[S_EOF] = ctrl_q.rx_en & rx_eof_evt;
    st_clr        = (wr_hit && bus_addr == A_STICKY) ? bus_wdata[N_STICKY-1:0] : '0;
  end

  irport_sticky #(.N(N_STICKY)) u_sticky (
    .clk   (clk),
    .rst_n (rst_int_n),
    .set   (st_set),
    .clr   (st_clr),
    .q     (st_q)
  );

  // live flags and interrupt
  logic tx_sr, rx_sr;
  logic [5:0] live;

  assign tx_sr = ctrl_q.txsr_en & (tx_count <= HALF);
  assign rx_sr = ctrl_q.rxsr_en & (rx_count >= HALF);
  assign live  = {~tx_full, ~rx_empty, rx_sync_in, tx_busy_in, rx_sr, tx_sr};
  assign irq   = (|st_q) | tx_sr | rx_sr;

  // read mux
  logic [DW-1:0] rd_val;

  always_comb begin
    case (bus_addr)
      A_CTRL_MAIN:  rd_val = {2'b00, ctrl_q.rx_inv, ctrl_q.tx_inv, ctrl_q.abort_mode,
                              ctrl_q.loopback, ctrl_q.rx_en, ctrl_q.tx_en};
      A_CTRL_SVC:   rd_val = {5'b00000, ctrl_q.match_en, ctrl_q.rxsr_en, ctrl_q.txsr_en};
      A_CTRL_MATCH: rd_val = ctrl_q.match_val;
      A_DATA:       rd_val = rx_empty ? '0 : rx_head;
      A_STICKY:     rd_val = {2'b00, st_q};
      A_LIVE:       rd_val = {2'b00, live};
      default:      rd_val = '0;
    endcase
  end

  assign bus_rdata = rd_hit ? rd_val : '0;

  // serial routing
  assign pin_own    = ~ctrl_q.loopback;
  assign pin_txd    = ctrl_q.loopback ? 1'b0 : (tx_ser_in ^ ctrl_q.tx_inv);
  assign rx_ser_out = ctrl_q.loopback ? tx_ser_in : (pin_rxd ^ ctrl_q.rx_inv);

  // R10
  underrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tx_pop_req && ctrl_q.tx_en && tx_empty) |=> st_q[S_UND]);

  // R3
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_hit && bus_addr == A_DATA && rx_empty) |-> (bus_rdata == '0));

  // R13
  rx_disabled_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!ctrl_q.rx_en) |=> (rx_count <= $past(rx_count)));

  // R10
  end_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(tx_end_abort && tx_end_eof));

endmodule

// File: tb/irport_regs_bench.sv
module irport_regs_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_sel, bus_wr, bus_rd;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       irq;
  logic       tx_pop_req;
  logic [7:0] tx_data;
  logic       tx_end_abort, tx_end_eof, tx_busy_in, tx_ser_in;
  logic       rx_byte_valid;
  logic [7:0] rx_byte;
  logic       rx_addr_flag, rx_crc_evt, rx_frame_evt, rx_abort_evt, rx_eof_evt, rx_sync_in;
  logic       rx_ser_out, pin_rxd, pin_txd, pin_own;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irport_regs #(.DEPTH(DEPTH)) u_irport_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .tx_pop_req(tx_pop_req), .tx_data(tx_data), .tx_end_abort(tx_end_abort),
    .tx_end_eof(tx_end_eof), .tx_busy_in(tx_busy_in), .tx_ser_in(tx_ser_in),
    .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte), .rx_addr_flag(rx_addr_flag),
    .rx_crc_evt(rx_crc_evt), .rx_frame_evt(rx_frame_evt), .rx_abort_evt(rx_abort_evt),
    .rx_eof_evt(rx_eof_evt), .rx_sync_in(rx_sync_in), .rx_ser_out(rx_ser_out),
    .pin_rxd(pin_rxd), .pin_txd(pin_txd), .pin_own(pin_own)
  );

  typedef struct packed {
    logic [1:0] op;    // 1 write, 2 read and compare
    logic [2:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{2'd2, 3'd0, 8'h00, 8'h00, 4'd1},   // R1 reset value
    '{2'd2, 3'd1, 8'h00, 8'h00, 4'd1},   // R1
    '{2'd2, 3'd2, 8'h00, 8'h00, 4'd1},   // R1
    '{2'd2, 3'd4, 8'h00, 8'h00, 4'd6},   // R6 no sticky bits
    '{2'd2, 3'd5, 8'h00, 8'h20, 4'd7},   // R7 only tx not full
    '{2'd1, 3'd0, 8'h3F, 8'h00, 4'd1},
    '{2'd2, 3'd0, 8'h00, 8'h3F, 4'd1},   // R1
    '{2'd1, 3'd1, 8'hFF, 8'h00, 4'd1},
    '{2'd2, 3'd1, 8'h00, 8'h07, 4'd1},   // R1 upper bits zero
    '{2'd1, 3'd2, 8'hA5, 8'h00, 4'd1},
    '{2'd2, 3'd2, 8'h00, 8'hA5, 4'd1},   // R1
    '{2'd1, 3'd0, 8'h00, 8'h00, 4'd1},
    '{2'd1, 3'd1, 8'h00, 8'h00, 4'd1},
    '{2'd2, 3'd3, 8'h00, 8'h00, 4'd3},   // R3 empty read
    '{2'd2, 3'd5, 8'h00, 8'h20, 4'd7},   // R7
    '{2'd1, 3'd1, 8'h01, 8'h00, 4'd8},
    '{2'd2, 3'd5, 8'h00, 8'h21, 4'd8},   // R8 empty tx raises request
    '{2'd1, 3'd1, 8'h00, 8'h00, 4'd8}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
    #1 chk(req, bus_rdata, exp);
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic pop_chk(input logic [7:0] exp, input string req);
    @(negedge clk);
    #1 chk(req, tx_data, exp);
    tx_pop_req = 1'b1;
    @(negedge clk);
    tx_pop_req = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] b, input logic is_addr);
    @(negedge clk);
    rx_byte_valid = 1'b1; rx_byte = b; rx_addr_flag = is_addr;
    @(negedge clk);
    rx_byte_valid = 1'b0; rx_addr_flag = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    tx_pop_req = 0; tx_busy_in = 0; tx_ser_in = 0;
    rx_byte_valid = 0; rx_byte = '0; rx_addr_flag = 0;
    rx_crc_evt = 0; rx_frame_evt = 0; rx_abort_evt = 0; rx_eof_evt = 0; rx_sync_in = 0;
    pin_rxd = 0;
    do_reset();
    #1 chk("R9 reset irq", {7'd0, irq}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].op == 2'd1) wr(VEC[i].addr, VEC[i].data);
      else rd(VEC[i].addr, VEC[i].exp, $sformatf("R%0d vector %0d", VEC[i].req, i));
    end

    // R2 R4: fill beyond depth, ninth byte dropped
    for (int i = 0; i < 9; i++) wr(3'd3, 8'h10 + 8'(i));
    rd(3'd5, 8'h00, "R4 tx full");
    // R13: disabled transmitter ignores pop request
    pop_chk(8'h10, "R13 head before");
    @(negedge clk); #1 chk("R13 head kept", tx_data, 8'h10);
    rd(3'd4, 8'h00, "R13 no underrun");
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h01);
    for (int i = 0; i < 3; i++) pop_chk(8'h10 + 8'(i), "R2 order");
    rd(3'd5, 8'h20, "R8 five left no request");
    pop_chk(8'h13, "R2 order");
    rd(3'd5, 8'h21, "R8 half raises request");
    for (int i = 4; i < 8; i++) pop_chk(8'h10 + 8'(i), "R2 order");
    @(negedge clk); #1 chk("R4 dropped byte absent", tx_data, 8'h00);
    wr(3'd1, 8'h00);

    // R10 underrun, end of frame mode
    @(negedge clk); tx_pop_req = 1'b1;
    #1 chk("R10 eof strobe", {6'd0, tx_end_abort, tx_end_eof}, 8'h01);
    @(negedge clk); tx_pop_req = 1'b0;
    rd(3'd4, 8'h04, "R10 underrun sticky");
    #1 chk("R9 irq from sticky", {7'd0, irq}, 8'h01);
    wr(3'd4, 8'h04);
    rd(3'd4, 8'h00, "R6 cleared");
    #1 chk("R9 irq drops", {7'd0, irq}, 8'h00);
    wr(3'd0, 8'h09);
    @(negedge clk); tx_pop_req = 1'b1;
    #1 chk("R10 abort strobe", {6'd0, tx_end_abort, tx_end_eof}, 8'h02);
    @(negedge clk); tx_pop_req = 1'b0;
    wr(3'd4, 8'h3F);

    // R5 R3 receive path and overrun
    wr(3'd0, 8'h02);
    for (int i = 0; i < 9; i++) rx_send(8'h31 + 8'(i), 1'b0);
    rd(3'd4, 8'h02, "R5 overrun");
    rd(3'd5, 8'h30, "R7 rx not empty");
    wr(3'd1, 8'h02);
    rd(3'd5, 8'h32, "R8 rx request");
    for (int i = 0; i < 5; i++) rd(3'd3, 8'h31 + 8'(i), "R3 order");
    rd(3'd5, 8'h30, "R8 below half");
    for (int i = 5; i < 8; i++) rd(3'd3, 8'h31 + 8'(i), "R3 order");
    rd(3'd3, 8'h00, "R3 empty read");
    rd(3'd5, 8'h20, "R3 empty after read");
    wr(3'd4, 8'h02);
    wr(3'd1, 8'h00);

    // R12 address matching
    wr(3'd1, 8'h04);
    rx_send(8'h5A, 1'b1);
    rx_send(8'h01, 1'b0);
    @(negedge clk); rx_eof_evt = 1'b1; @(negedge clk); rx_eof_evt = 1'b0;
    rx_send(8'hA5, 1'b1);
    rx_send(8'h02, 1'b0);
    rd(3'd4, 8'h20, "R6 eof sticky");
    rd(3'd3, 8'hA5, "R12 matching address kept");
    rd(3'd3, 8'h02, "R12 matching data kept");
    rd(3'd3, 8'h00, "R12 mismatched frame dropped");
    wr(3'd4, 8'h20);

    // R6 event mix and set-wins collision
    @(negedge clk); rx_crc_evt = 1; rx_frame_evt = 1; rx_abort_evt = 1;
    @(negedge clk); rx_crc_evt = 0; rx_frame_evt = 0; rx_abort_evt = 0;
    rd(3'd4, 8'h19, "R6 event bits");
    @(negedge clk);
    rx_crc_evt = 1; bus_sel = 1; bus_wr = 1; bus_addr = 3'd4; bus_wdata = 8'h01;
    @(negedge clk);
    rx_crc_evt = 0; bus_sel = 0; bus_wr = 0;
    rd(3'd4, 8'h19, "R6 set wins");
    wr(3'd4, 8'hFF);
    rd(3'd4, 8'h00, "R6 all cleared");

    // R7 R9 status-only flags
    tx_busy_in = 1; rx_sync_in = 1;
    rd(3'd5, 8'h2C, "R7 busy and sync");
    #1 chk("R9 status-only no irq", {7'd0, irq}, 8'h00);
    tx_busy_in = 0; rx_sync_in = 0;

    // R11 polarity and loopback
    wr(3'd0, 8'h30);
    @(negedge clk); tx_ser_in = 1; pin_rxd = 0;
    #1 chk("R11 normal pins", {5'd0, pin_own, pin_txd, rx_ser_out}, 8'h05);
    wr(3'd0, 8'h04);
    @(negedge clk); tx_ser_in = 1; pin_rxd = 0;
    #1 chk("R11 loop high", {5'd0, pin_own, pin_txd, rx_ser_out}, 8'h01);
    tx_ser_in = 0; pin_rxd = 1;
    #1 chk("R11 loop low", {5'd0, pin_own, pin_txd, rx_ser_out}, 8'h00);

    // R13 receiver disabled
    wr(3'd0, 8'h00);
    rx_send(8'h77, 1'b0);
    @(negedge clk); rx_crc_evt = 1; @(negedge clk); rx_crc_evt = 0;
    rd(3'd4, 8'h00, "R13 events ignored");
    rd(3'd3, 8'h00, "R13 byte ignored");

    // R1 reset in mid run
    wr(3'd0, 8'h3F);
    do_reset();
    rd(3'd0, 8'h00, "R1 after reset");
    rd(3'd5, 8'h20, "R7 after reset");

    summary();
  end

endmodule